// File: doc/BRIEF.md
# Interrupt Distributor Register Access Engine

This block is the register port of an interrupt distributor. A requester presents one access at a time: a byte offset, a length in bytes, a direction and write data. The engine decodes the offset into a register and an access policy, then performs the access on a 32-bit view of the backing state. Reads take the addressed byte lanes. Writes are masked to the access length and shifted into the addressed lanes. Depending on the register, a write then sets bits, clears bits, replaces the addressed lanes or is ignored. The block holds the global enable flag, the interrupt enable bitmap, the pending bitmap and the edge/level configuration. Enable and pending each have a set alias and a clear alias. The configuration stores one bit per interrupt. On the bus it appears in a two-bits-per-interrupt layout.

The controller has three states. S_IDLE waits with `req_ready` high. A request moves it to S_APPLY when `req_len` is 4 or less, and to S_ABORT when `req_len` is above 4. S_APPLY reads the addressed register, commits any write and registers the response. S_ABORT registers an abort response and touches no state. Both S_APPLY and S_ABORT return to S_IDLE unconditionally. The response is visible for one cycle, two clock edges after the edge that accepts the request. `state_changed` pulses with the response of every write to the control, enable or pending registers, so that a pending evaluator downstream can recompute.

Top module: `dist_reg_engine`

## Requirements
- R1: The 3-bit access code is {write policy[1:0], read bit}. Read bit 1 returns the register, 0 returns zero. Write policy 0 ignores, 1 sets bits, 2 clears bits, 3 replaces lanes. Offsets that match no register read as zero and ignore writes. The clear aliases read back the same bitmap as the set aliases.
- R2: Write data is masked to `req_len` bytes (1, 2 or 4), then shifted left by 8 times `req_addr[1:0]` before the policy is applied.
- R3: A replace write changes only the addressed lanes: new = (old & ~(mask << shift)) | data.
- R4: Read data is the register shifted right by 8 times `req_addr[1:0]` and masked to `req_len` bytes.
- R5: A request with `req_len` greater than 4 returns `rsp_abort`=1 and `rsp_rdata`=0. It changes no state and does not pulse `state_changed`.
- R6: Enable bits 15:0 always read as 1. A clear-enable write to word 0 (offset 0x180) cannot clear them.
- R7: The configuration window at 0xC00 holds one word per 16 interrupts. A read shows the stored bit of interrupt i at bit 2i+1 and a 0 at bit 2i. A write stores the odd bits.
- R8: A write to configuration word 0 discards the data and sets the stored bits of interrupts 0 to 31 to 1.
- R9: Control (0x000) keeps only bit 0 and is replace-written. The type register (0x004) reads (NUM_CPUS-1) in bits 7:5 and (NUM_IRQS/32-1) in bits 4:0, and ignores writes.
- R10: `state_changed` is a one-cycle pulse, aligned with the response, on a non-aborted write to control, set-enable (0x100), clear-enable (0x180), set-pending (0x200) or clear-pending (0x280). It stays low for every other access.
- R11: Reset clears control, pending and enable state except enable bits 15:0. It sets the stored configuration bits of interrupts 0 to 31 to 1 and clears all other configuration bits.
- R12: `req_ready` is high only in S_IDLE. Each accepted request gets exactly one `rsp_valid` pulse, two edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset into the register space |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response strobe |
| rsp_abort | output | 1 | Access refused (too long) |
| rsp_rdata | output | 32 | Read data, right-aligned |
| state_changed | output | 1 | Enable, pending or control state was written |

## Verification
The assertions assume that `req_valid` is raised only while `req_ready` is high, and only one request at a time. They also assume that accepted lengths keep the lane offset plus length within one word. The stimulus drives one request, waits for its response, and picks lengths of 1, 2 or 4 with a lane offset aligned to the length. Occasional lengths of 5 to 8 exercise the abort path. A reference model inside the bench predicts every read value and every `state_changed` pulse.

// File: rtl/dist_regs_pkg.sv
package dist_regs_pkg;
    localparam int ADDR_W = 12;

    // register blocks selected by addr[11:7]
    localparam logic [4:0] BLK_MISC    = 5'h00;
    localparam logic [4:0] BLK_EN_SET  = 5'h02;
    localparam logic [4:0] BLK_EN_CLR  = 5'h03;
    localparam logic [4:0] BLK_PD_SET  = 5'h04;
    localparam logic [4:0] BLK_PD_CLR  = 5'h05;
    localparam logic [4:0] BLK_CFG_LO  = 5'h18;
    localparam logic [4:0] BLK_CFG_HI  = 5'h19;

    typedef enum logic [1:0] {
        WR_IGNORE  = 2'd0,
        WR_SET     = 2'd1,
        WR_CLEAR   = 2'd2,
        WR_REPLACE = 2'd3
    } wr_pol_t;

    typedef struct packed {
        wr_pol_t wr;
        logic    rd_value;
    } acc_mode_t;

    typedef enum logic [2:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_EN_SET, RG_EN_CLR, RG_PD_SET, RG_PD_CLR, RG_CFG
    } region_t;

    function automatic logic [31:0] cfg_expand(input logic [15:0] v);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 16; i++) r[2*i+1] = v[i];
        return r;
    endfunction

    function automatic logic [15:0] cfg_compress(input logic [31:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[2*i+1];
        return r;
    endfunction
endpackage

// File: rtl/dist_addr_decode.sv
module dist_addr_decode
    import dist_regs_pkg::*;
#(
    parameter int NUM_IRQS = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output acc_mode_t         mode,
    output logic [((NUM_IRQS/32 > 1) ? $clog2(NUM_IRQS/32) : 1)-1:0] bmp_idx,
    output logic [$clog2(NUM_IRQS/16)-1:0] cfg_idx
);
    localparam int BMP_WORDS = NUM_IRQS / 32;
    localparam int CFG_WORDS = NUM_IRQS / 16;
    localparam int BIDX_W    = (BMP_WORDS > 1) ? $clog2(BMP_WORDS) : 1;
    localparam int CIDX_W    = $clog2(CFG_WORDS);

    logic [4:0] blk;
    logic [5:0] word;

    assign blk     = addr[11:7];
    assign word    = addr[7:2];
    assign bmp_idx = word[BIDX_W-1:0];
    assign cfg_idx = word[CIDX_W-1:0];

    always_comb begin
        region = RG_NONE;
        case (blk)
            BLK_MISC: begin
                if (word == 6'd0)      region = RG_CTRL;
                else if (word == 6'd1) region = RG_TYPE;
            end
            BLK_EN_SET: if (int'(word[4:0]) < BMP_WORDS) region = RG_EN_SET;
            BLK_EN_CLR: if (int'(word[4:0]) < BMP_WORDS) region = RG_EN_CLR;
            BLK_PD_SET: if (int'(word[4:0]) < BMP_WORDS) region = RG_PD_SET;
            BLK_PD_CLR: if (int'(word[4:0]) < BMP_WORDS) region = RG_PD_CLR;
            BLK_CFG_LO, BLK_CFG_HI: if (int'(word) < CFG_WORDS) region = RG_CFG;
            default: region = RG_NONE;
        endcase
    end

    always_comb begin
        unique case (region)
            RG_CTRL:   mode = '{wr: WR_REPLACE, rd_value: 1'b1};
            RG_TYPE:   mode = '{wr: WR_IGNORE,  rd_value: 1'b1};
            RG_EN_SET: mode = '{wr: WR_SET,     rd_value: 1'b1};
            RG_EN_CLR: mode = '{wr: WR_CLEAR,   rd_value: 1'b1};
            RG_PD_SET: mode = '{wr: WR_SET,     rd_value: 1'b1};
            RG_PD_CLR: mode = '{wr: WR_CLEAR,   rd_value: 1'b1};
            RG_CFG:    mode = '{wr: WR_REPLACE, rd_value: 1'b1};
            RG_NONE:   mode = '{wr: WR_IGNORE,  rd_value: 1'b0};
        endcase
    end
endmodule

// File: rtl/dist_lane_access.sv
module dist_lane_access
    import dist_regs_pkg::*;
(
    input  acc_mode_t   mode,
    input  logic [31:0] old_val,
    input  logic [31:0] wdata,
    input  logic [3:0]  len,
    input  logic [1:0]  lane,
    output logic [31:0] new_val,
    output logic [31:0] rd_val
);
    logic [31:0] mask;
    logic [31:0] data;
    logic [4:0]  shamt;

    assign shamt = {lane, 3'b000};

    always_comb begin
        case (len)
            4'd1:    mask = 32'h0000_00FF;
            4'd2:    mask = 32'h0000_FFFF;
            4'd3:    mask = 32'h00FF_FFFF;
            4'd4:    mask = 32'hFFFF_FFFF;
            default: mask = 32'h0000_0000;
        endcase
    end

    assign data = (wdata & mask) << shamt;

    always_comb begin
        unique case (mode.wr)
            WR_IGNORE:  new_val = old_val;
            WR_SET:     new_val = old_val | data;
            WR_CLEAR:   new_val = old_val & ~data;
            WR_REPLACE: new_val = (old_val & ~(mask << shamt)) | data;
        endcase
    end

    assign rd_val = mode.rd_value ? ((old_val >> shamt) & mask) : 32'd0;
endmodule

// File: rtl/dist_reg_engine.sv
module dist_reg_engine
    import dist_regs_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_IRQS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [3:0]  req_len,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_abort,
    output logic [31:0] rsp_rdata,
    output logic        state_changed
);
    localparam int BMP_WORDS = NUM_IRQS / 32;
    localparam int CFG_WORDS = NUM_IRQS / 16;
    localparam int BIDX_W    = (BMP_WORDS > 1) ? $clog2(BMP_WORDS) : 1;
    localparam int CIDX_W    = $clog2(CFG_WORDS);
    localparam logic [31:0] TYPE_VAL = {24'd0, 3'(NUM_CPUS - 1), 5'(NUM_IRQS / 32 - 1)};

    typedef enum logic [1:0] {S_IDLE, S_APPLY, S_ABORT} state_t;

    state_t state, state_nx;

    logic              q_write;
    logic [11:0]       q_addr;
    logic [3:0]        q_len;
    logic [31:0]       q_wdata;

    logic              ctrl_en;
    logic [31:0]       en_w  [BMP_WORDS];
    logic [31:0]       pd_w  [BMP_WORDS];
    logic [15:0]       cfg_w [CFG_WORDS];

    region_t           region;
    acc_mode_t         mode;
    logic [BIDX_W-1:0] bmp_idx;
    logic [CIDX_W-1:0] cfg_idx;
    logic [31:0]       old_val, new_val, rd_val;
    logic              do_write, notify;

    dist_addr_decode #(.NUM_IRQS(NUM_IRQS)) u_decode (
        .addr(q_addr), .region(region), .mode(mode),
        .bmp_idx(bmp_idx), .cfg_idx(cfg_idx)
    );

    dist_lane_access u_lane (
        .mode(mode), .old_val(old_val), .wdata(q_wdata), .len(q_len),
        .lane(q_addr[1:0]), .new_val(new_val), .rd_val(rd_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = (req_len > 4'd4) ? S_ABORT : S_APPLY;
            S_APPLY: state_nx = S_IDLE;
            S_ABORT: state_nx = S_IDLE;
        endcase
    end

    assign req_ready = (state == S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_addr  <= '0;
            q_len   <= '0;
            q_wdata <= '0;
        end else if (state == S_IDLE && req_valid) begin
            q_write <= req_write;
            q_addr  <= req_addr;
            q_len   <= req_len;
            q_wdata <= req_wdata;
        end
    end

    always_comb begin
        case (region)
            RG_CTRL:              old_val = {31'd0, ctrl_en};
            RG_TYPE:              old_val = TYPE_VAL;
            RG_EN_SET, RG_EN_CLR: old_val = en_w[bmp_idx];
            RG_PD_SET, RG_PD_CLR: old_val = pd_w[bmp_idx];
            RG_CFG:               old_val = cfg_expand(cfg_w[cfg_idx]);
            default:              old_val = 32'd0;
        endcase
    end

    assign do_write = (state == S_APPLY) && q_write;
    assign notify   = do_write && (region inside {RG_CTRL, RG_EN_SET, RG_EN_CLR, RG_PD_SET, RG_PD_CLR});

    // backing storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            for (int i = 0; i < BMP_WORDS; i++) begin
                en_w[i] <= (i == 0) ? 32'h0000_FFFF : 32'd0;
                pd_w[i] <= 32'd0;
            end
            for (int i = 0; i < CFG_WORDS; i++) cfg_w[i] <= (i < 2) ? 16'hFFFF : 16'h0000;
        end else if (do_write) begin
            case (region)
                RG_CTRL:   ctrl_en <= new_val[0];
                RG_EN_SET: en_w[bmp_idx] <= new_val;
                RG_EN_CLR: en_w[bmp_idx] <= (bmp_idx == '0) ? (new_val | 32'h0000_FFFF) : new_val;
                RG_PD_SET, RG_PD_CLR: pd_w[bmp_idx] <= new_val;
                RG_CFG: begin
                    if (cfg_idx == '0) begin
                        cfg_w[0] <= 16'hFFFF;
                        cfg_w[1] <= 16'hFFFF;
                    end else begin
                        cfg_w[cfg_idx] <= cfg_compress(new_val);
                    end
                end
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_abort     <= 1'b0;
            rsp_rdata     <= 32'd0;
            state_changed <= 1'b0;
        end else begin
            rsp_valid     <= (state == S_APPLY) || (state == S_ABORT);
            rsp_abort     <= (state == S_ABORT);
            rsp_rdata     <= ((state == S_APPLY) && !q_write) ? rd_val : 32'd0;
            state_changed <= notify;
        end
    end

    // R12: every accepted request is answered two edges later
    a_r12_response_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);

    // R5: over-long requests abort without announcing a change
    a_r5_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len > 4'd4) |-> ##2 (rsp_abort && !state_changed && rsp_rdata == 32'd0));

    // R10: change strobe lasts one cycle and rides a normal response
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        state_changed |=> !state_changed);
    a_r10_with_response: assert property (@(posedge clk) disable iff (!rst_n)
        state_changed |-> (rsp_valid && !rsp_abort));

    // R6: the low private enable bits never drop
    a_r6_sgi_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        en_w[0][15:0] == 16'hFFFF);

    // R8: private configuration of interrupts 0..15 stays all ones
    a_r8_private_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_w[0] == 16'hFFFF);
endmodule

// File: tb/dist_reg_engine_test.sv
module dist_reg_engine_test;
    localparam int NCPU = 8;
    localparam int NIRQ = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_abort, state_changed;
    logic [31:0] rsp_rdata;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_ctrl;
    logic [NIRQ-1:0] m_en, m_pd, m_cfg;

    always #2 clk = ~clk;

    dist_reg_engine #(.NUM_CPUS(NCPU), .NUM_IRQS(NIRQ)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_abort(rsp_abort),
        .rsp_rdata(rsp_rdata), .state_changed(state_changed)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 none, 1 ctrl, 2 type, 3 en set, 4 en clr, 5 pd set, 6 pd clr, 7 cfg
    function automatic int kind_of(input logic [11:0] a);
        int w;
        if (a < 12'h080) begin
            if (a[6:2] == 5'd0) return 1;
            if (a[6:2] == 5'd1) return 2;
            return 0;
        end
        w = int'(a[6:2]);
        if (a >= 12'h100 && a < 12'h180) return (w < NIRQ/32) ? 3 : 0;
        if (a >= 12'h180 && a < 12'h200) return (w < NIRQ/32) ? 4 : 0;
        if (a >= 12'h200 && a < 12'h280) return (w < NIRQ/32) ? 5 : 0;
        if (a >= 12'h280 && a < 12'h300) return (w < NIRQ/32) ? 6 : 0;
        if (a >= 12'hC00 && int'(a - 12'hC00) < NIRQ/4) return 7;
        return 0;
    endfunction

    function automatic logic [31:0] model_get(input int k, input int w);
        logic [31:0] v;
        v = '0;
        case (k)
            1: v = {31'd0, m_ctrl};
            2: v = ((NCPU - 1) << 5) | (NIRQ/32 - 1);
            3, 4: v = m_en[w*32 +: 32];
            5, 6: v = m_pd[w*32 +: 32];
            7: for (int i = 0; i < 16; i++) v[2*i+1] = m_cfg[w*16 + i];
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [31:0] len_mask(input logic [3:0] len);
        if (len == 4'd1) return 32'hFF;
        if (len == 4'd2) return 32'hFFFF;
        if (len == 4'd3) return 32'hFF_FFFF;
        if (len == 4'd4) return 32'hFFFF_FFFF;
        return 32'd0;
    endfunction

    task automatic model_write(input int k, input int w, input logic [31:0] wd,
                               input logic [3:0] len, input logic [1:0] lane);
        logic [31:0] old, d, m, nv;
        int sh;
        sh  = 8 * int'(lane);
        m   = len_mask(len);
        old = model_get(k, w);
        d   = (wd & m) << sh;
        case (k)
            3, 5:    nv = old | d;
            4, 6:    nv = old & ~d;
            1, 7:    nv = (old & ~(m << sh)) | d;
            default: nv = old;
        endcase
        case (k)
            1: m_ctrl = nv[0];
            3, 4: begin
                m_en[w*32 +: 32] = nv;
                if (k == 4 && w == 0) m_en[15:0] = 16'hFFFF;
            end
            5, 6: m_pd[w*32 +: 32] = nv;
            7: begin
                if (w == 0) m_cfg[31:0] = 32'hFFFF_FFFF;
                else for (int i = 0; i < 16; i++) m_cfg[w*16 + i] = nv[2*i+1];
            end
            default: ;
        endcase
    endtask

    task automatic access(input bit wr, input logic [11:0] a, input logic [3:0] len,
                          input logic [31:0] wd, input string req);
        int k, w;
        bit exp_abort, exp_ch;
        logic [31:0] exp_rd;
        k = kind_of(a);
        w = (k == 7) ? int'(a[7:2]) : int'(a[6:2]);
        exp_abort = (len > 4'd4);
        exp_rd = (wr || exp_abort || k == 0) ? 32'd0
               : ((model_get(k, w) >> (8 * int'(a[1:0]))) & len_mask(len));
        exp_ch = wr && !exp_abort && (k == 1 || (k >= 3 && k <= 6));
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid && (rsp_abort == exp_abort), exp_abort ? "R5 abort" : "R12 response",
            {30'd0, rsp_valid, rsp_abort}, {30'd0, 1'b1, exp_abort});
        if (!wr) chk(rsp_rdata == exp_rd, req, rsp_rdata, exp_rd);
        chk(state_changed == exp_ch, "R10 state_changed", {31'd0, state_changed}, {31'd0, exp_ch});
        if (wr && !exp_abort) model_write(k, w, wd, len, a[1:0]);
    endtask

    initial begin
        m_ctrl = 1'b0;
        m_en   = 64'h0000_0000_0000_FFFF;
        m_pd   = '0;
        m_cfg  = 64'h0000_0000_FFFF_FFFF;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !state_changed && req_ready, "R11 R12 idle after reset",
            {29'd0, rsp_valid, state_changed, req_ready}, 32'd1);

        // R11: reset contents
        access(0, 12'h000, 4, 0, "R11 ctrl reset");
        access(0, 12'h100, 4, 0, "R11 enable word0 reset");
        access(0, 12'h104, 4, 0, "R11 enable word1 reset");
        access(0, 12'h200, 4, 0, "R11 pending reset");
        access(0, 12'hC00, 4, 0, "R11 cfg word0 reset");
        access(0, 12'hC04, 4, 0, "R11 cfg word1 reset");
        access(0, 12'hC08, 4, 0, "R11 cfg word2 reset");
        // R9: control and type
        access(0, 12'h004, 4, 0, "R9 type value");
        chk(rsp_rdata == 32'h0000_00E1, "R9 type literal", rsp_rdata, 32'h0000_00E1);
        access(1, 12'h004, 4, 32'hFFFF_FFFF, "R9 type write");
        access(0, 12'h004, 4, 0, "R9 type after write");
        access(1, 12'h000, 4, 32'hFFFF_FFFF, "R9 ctrl write");
        access(0, 12'h000, 4, 0, "R9 ctrl keeps bit0");
        chk(rsp_rdata == 32'd1, "R9 ctrl literal", rsp_rdata, 32'd1);
        // R3: replace of lane 1 leaves lane 0
        access(1, 12'h001, 1, 32'h0, "R3 ctrl lane1 replace");
        access(0, 12'h000, 4, 0, "R3 ctrl after lane replace");
        // R2, R4: byte set and lane reads
        access(1, 12'h105, 1, 32'h0000_01FF, "R2 byte set enable");
        access(0, 12'h104, 4, 0, "R2 enable word1");
        chk(rsp_rdata == 32'h0000_FF00, "R2 enable literal", rsp_rdata, 32'h0000_FF00);
        access(0, 12'h105, 1, 0, "R4 byte lane read");
        access(0, 12'h106, 2, 0, "R4 half lane read");
        // R1: clear alias reads back, unmapped RAZ/WI
        access(0, 12'h184, 4, 0, "R1 clear alias reads value");
        access(1, 12'h040, 4, 32'hFFFF_FFFF, "R1 unmapped write");
        access(0, 12'h040, 4, 0, "R1 unmapped read zero");
        // R6
        access(1, 12'h180, 4, 32'hFFFF_FFFF, "R6 clear enable word0");
        access(0, 12'h100, 4, 0, "R6 private enables stay");
        chk(rsp_rdata == 32'h0000_FFFF, "R6 literal", rsp_rdata, 32'h0000_FFFF);
        // R7, R3: half replace in cfg
        access(1, 12'hC0A, 2, 32'h0000_FFFF, "R7 cfg half write");
        access(0, 12'hC08, 4, 0, "R7 cfg expanded read");
        chk(rsp_rdata == 32'hAAAA_0000, "R7 cfg literal", rsp_rdata, 32'hAAAA_0000);
        access(1, 12'hC0C, 4, 32'h5555_0003, "R7 cfg odd bits only");
        access(0, 12'hC0C, 4, 0, "R7 cfg compress readback");
        // R8
        access(1, 12'hC04, 4, 32'h0, "R8 cfg word1 writable");
        access(1, 12'hC00, 4, 32'h0, "R8 cfg word0 write");
        access(0, 12'hC00, 4, 0, "R8 cfg word0 forced");
        access(0, 12'hC04, 4, 0, "R8 cfg word1 forced");
        // R5
        access(1, 12'h200, 8, 32'hFFFF_FFFF, "R5 long write");
        access(0, 12'h200, 4, 0, "R5 pending untouched");
        access(0, 12'h000, 6, 0, "R5 long read");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int r, lens, lane;
            logic [11:0] a;
            logic [3:0] len;
            r = int'($urandom % 8);
            lens = int'($urandom % 3);
            len = (lens == 0) ? 4'd1 : (lens == 1) ? 4'd2 : 4'd4;
            lane = int'($urandom % 4) & ~(int'(len) - 1);
            case (r)
                0: a = 12'h000;
                1: a = 12'h004;
                2: a = 12'h100 + 12'(4 * int'($urandom % 2));
                3: a = 12'h180 + 12'(4 * int'($urandom % 2));
                4: a = 12'h200 + 12'(4 * int'($urandom % 2));
                5: a = 12'h280 + 12'(4 * int'($urandom % 2));
                6: a = 12'hC00 + 12'(4 * int'($urandom % 4));
                default: a = ($urandom % 2 == 0) ? 12'h010 : 12'h300;
            endcase
            a = a + 12'(lane);
            if ($urandom % 16 == 0) len = 4'(5 + $urandom % 4);
            access(($urandom % 2) == 1, a, len, $urandom, "R1 R2 R3 R4 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule